// File: doc/BRIEF.md
# DDR2 Posted-CAS Command Latency Controller

This block models the command-timing part of a DDR2 memory device. All commands arrive on a single valid/ready command channel. A mode-register-set command writes one of four mode registers, and the low two bank bits pick which one. From those writes the block keeps a CAS latency, an additive latency and a self-refresh temperature setting. READ and WRITE commands may be sent early. Each one is held for the additive latency and then presented on the internal issue outputs with its own bank and column. Two single-cycle strobes then mark when read data is due on the bus and when write data must be captured.

The command channel has no back-pressure in normal operation: `cmd_ready` is high in every cycle except during reset. A command counts as accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. The issue and strobe outputs are plain pulses with no ready. The receiver must take them in the cycle they appear.

Cycle numbering: a command presented in cycle t has its effect on the outputs in cycle t+N, as each requirement states. Mode-register values and the error flags change in cycle t+1 after an MRS in cycle t. A latency change applies at once to commands that are already in flight, so software lets the pipeline drain before it changes a latency.

Top module: `pcas_latency_ctrl`

## Requirements
- R1: `cmd_op` encodes 00 = MRS, 01 = READ, 10 = WRITE. For an MRS, `cmd_ba[1:0]` picks the target: 00 = MR, 01 = EMR, 10 = EMR2, 11 = EMR3. A write to EMR3 changes none of the outputs.
- R2: An MR write takes the CAS latency from `cmd_addr[6:4]` in binary. Codes 3..6 are stored and appear on `cl_value` in the next cycle. Any other code leaves `cl_value` unchanged and pulses `mrs_illegal` in the next cycle.
- R3: An EMR write takes the additive latency from `cmd_addr[5:3]` in binary. Codes 0..6 are stored and appear on `al_value`. Code 7 leaves `al_value` unchanged and pulses `mrs_illegal` in the next cycle.
- R4: An EMR2 write copies `cmd_addr[7]` to `srt_2x`. A value of 1 selects the doubled refresh rate for high temperature, and 0 selects the normal rate.
- R5: An MRS with `cmd_ba[2]` set, or with any of `cmd_addr[15:13]` set, is discarded. `mrs_reserved` pulses in the next cycle and no setting changes.
- R6: A READ or WRITE accepted in cycle t drives `iss_valid` in cycle t+AL. In that cycle `iss_write` is 1 for a WRITE, `iss_ba` equals the command's `cmd_ba`, and `iss_col` equals its `cmd_addr[9:0]`. When AL = 0 this happens in cycle t itself.
- R7: A READ accepted in cycle t pulses `rd_due` in cycle t+AL+CL.
- R8: A WRITE accepted in cycle t pulses `wr_due` in cycle t+AL+CL-1.
- R9: READ and WRITE commands on consecutive cycles each come out once, in order, with their own bank and column, up to AL = 6 and CL = 6.
- R10: While `cl_value` is 0, `rd_due` and `wr_due` stay low. Issue still follows R6.
- R11: Synchronous active-high `rst` clears `cl_value`, `al_value`, `srt_2x` and both flags. It also drops every in-flight command, so none of them is issued or strobed after reset.
- R12: `cmd_ready` is 0 while `rst` is high and 1 otherwise. A valid command with `cmd_op` = 11 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | Command kind: 00 MRS, 01 READ, 10 WRITE, 11 none |
| cmd_ba | input | 3 | Bank address; for MRS, bits 1:0 pick the register and bit 2 is reserved |
| cmd_addr | input | 16 | Address; MRS payload or column in bits 9:0 |
| iss_valid | output | 1 | Internal issue of a delayed READ/WRITE |
| iss_write | output | 1 | Issued command is a WRITE |
| iss_ba | output | 3 | Bank of the issued command |
| iss_col | output | 10 | Column of the issued command |
| rd_due | output | 1 | Read data must appear in this cycle |
| wr_due | output | 1 | Write data is captured in this cycle |
| cl_value | output | 3 | Stored CAS latency (0 = not programmed) |
| al_value | output | 3 | Stored additive latency |
| srt_2x | output | 1 | Self-refresh temperature: 1 = doubled rate |
| mrs_illegal | output | 1 | Pulse: MRS carried an illegal latency code |
| mrs_reserved | output | 1 | Pulse: MRS had reserved bits set and was dropped |

## Verification
The hardest case to reach is a pipeline holding several commands at the deepest setting, AL = 6 with CL = 6, that reset then empties. Commands that are still only part way through the history must not come out later. The stimulus first programs both maximum latencies and sends back-to-back reads. It asserts reset while those reads are still several stages short of their issue tap. The scoreboard then drops its expectations, so any later issue or strobe shows up as an unexpected item. The zero-additive-latency path, where issue happens in the same cycle as acceptance, and the unprogrammed-CAS state just after reset are also visited.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

  typedef enum logic [1:0] {
    OP_MRS  = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_NONE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_MR   = 2'b00,
    SEL_EMR  = 2'b01,
    SEL_EMR2 = 2'b10,
    SEL_EMR3 = 2'b11
  } msel_e;

  localparam int LAT_W    = 3;
  localparam int AL_MAX   = 6;
  localparam int CL_MIN   = 3;
  localparam int CL_MAX   = 6;
  localparam int CL_LSB   = 4;
  localparam int AL_LSB   = 3;
  localparam int SRT_BIT  = 7;
  localparam int RSV_LSB  = 13;

endpackage

// File: rtl/pcas_mode_regs.sv
module pcas_mode_regs
  import pcas_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_fire,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [LAT_W-1:0]  cl_q,
  output logic [LAT_W-1:0]  al_q,
  output logic              srt_q,
  output logic              ill_q,
  output logic              rsv_q
);

  logic             rsv_hit;
  msel_e            sel;
  logic [LAT_W-1:0] cl_code;
  logic [LAT_W-1:0] al_code;
  logic             cl_ok;
  logic             al_ok;

  always_comb begin
    rsv_hit = (ba[BA_W-1:2] != '0) || (addr[ADDR_W-1:RSV_LSB] != '0);
    sel     = msel_e'(ba[1:0]);
    cl_code = addr[CL_LSB +: LAT_W];
    al_code = addr[AL_LSB +: LAT_W];
    cl_ok   = (int'(cl_code) >= CL_MIN) && (int'(cl_code) <= CL_MAX);
    al_ok   = int'(al_code) <= AL_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q  <= '0;
      al_q  <= '0;
      srt_q <= 1'b0;
      ill_q <= 1'b0;
      rsv_q <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      rsv_q <= 1'b0;
      if (mrs_fire) begin
        if (rsv_hit) begin
          rsv_q <= 1'b1;
        end else begin
          case (sel)
            SEL_MR: begin
              if (cl_ok) cl_q <= cl_code;
              else       ill_q <= 1'b1;
            end
            SEL_EMR: begin
              if (al_ok) al_q <= al_code;
              else       ill_q <= 1'b1;
            end
            SEL_EMR2: srt_q <= addr[SRT_BIT];
            default: ;
          endcase
        end
      end
    end
  end

  // R2
  cl_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mrs_fire && !rsv_hit && sel == SEL_MR && !cl_ok) |=> ($stable(cl_q) && ill_q));

  // R3
  al_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mrs_fire && !rsv_hit && sel == SEL_EMR && !al_ok) |=> ($stable(al_q) && ill_q));

  // R5
  rsv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mrs_fire && rsv_hit) |=> (rsv_q && $stable(cl_q) && $stable(al_q) && $stable(srt_q)));

  // R1
  emr3_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mrs_fire && !rsv_hit && sel == SEL_EMR3) |=> ($stable(cl_q) && $stable(al_q) && $stable(srt_q) && !ill_q));

endmodule

// File: rtl/pcas_delay_line.sv
module pcas_delay_line #(
  parameter int DEPTH = 12,
  parameter int W     = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic [W-1:0]            in_d,
  output logic [DEPTH-1:0]        hv,
  output logic [DEPTH-1:0][W-1:0] hd
);

  logic         v_r [DEPTH];
  logic [W-1:0] d_r [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    if (j == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_r[j] <= 1'b0;
          d_r[j] <= '0;
        end else begin
          v_r[j] <= in_v;
          d_r[j] <= in_d;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          v_r[j] <= 1'b0;
          d_r[j] <= '0;
        end else begin
          v_r[j] <= v_r[j-1];
          d_r[j] <= d_r[j-1];
        end
      end
    end
    assign hv[j] = v_r[j];
    assign hd[j] = d_r[j];
  end

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hv == '0));

endmodule

// File: rtl/pcas_tap.sv
module pcas_tap #(
  parameter int DEPTH = 12,
  parameter int W     = 14,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic                    now_v,
  input  logic [W-1:0]            now_d,
  input  logic [DEPTH-1:0]        hv,
  input  logic [DEPTH-1:0][W-1:0] hd,
  output logic                    v,
  output logic [W-1:0]            d
);

  always_comb begin
    v = 1'b0;
    d = '0;
    if (sel == '0) begin
      v = now_v;
      d = now_d;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (int'(sel) == j + 1) begin
          v = hv[j];
          d = hd[j];
        end
      end
    end
  end

endmodule

// File: rtl/pcas_latency_ctrl.sv
module pcas_latency_ctrl
  import pcas_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [BA_W-1:0]   iss_ba,
  output logic [COL_W-1:0]  iss_col,
  output logic              rd_due,
  output logic              wr_due,
  output logic [LAT_W-1:0]  cl_value,
  output logic [LAT_W-1:0]  al_value,
  output logic              srt_2x,
  output logic              mrs_illegal,
  output logic              mrs_reserved
);

  localparam int DEPTH = AL_MAX + CL_MAX;
  localparam int W     = 1 + BA_W + COL_W;
  localparam int SEL_W = $clog2(DEPTH + 1);

  op_e  op;
  logic acc, mrs_fire, rw_fire;
  logic [W-1:0] now_d;

  always_comb begin
    op        = op_e'(cmd_op);
    cmd_ready = ~rst;
    acc       = cmd_valid & cmd_ready;
    mrs_fire  = acc && (op == OP_MRS);
    rw_fire   = acc && ((op == OP_RD) || (op == OP_WR));
    now_d     = {op == OP_WR, cmd_ba, cmd_addr[COL_W-1:0]};
  end

  pcas_mode_regs #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst), .mrs_fire(mrs_fire), .ba(cmd_ba), .addr(cmd_addr),
    .cl_q(cl_value), .al_q(al_value), .srt_q(srt_2x),
    .ill_q(mrs_illegal), .rsv_q(mrs_reserved)
  );

  logic [DEPTH-1:0]        hv;
  logic [DEPTH-1:0][W-1:0] hd;

  pcas_delay_line #(.DEPTH(DEPTH), .W(W)) u_line (
    .clk(clk), .rst(rst), .in_v(rw_fire), .in_d(now_d), .hv(hv), .hd(hd)
  );

  logic [SEL_W-1:0] sel_iss, sel_rd, sel_wr;
  logic             cl_set;

  always_comb begin
    cl_set  = cl_value != '0;
    sel_iss = SEL_W'(al_value);
    sel_rd  = SEL_W'(al_value) + SEL_W'(cl_value);
    sel_wr  = cl_set ? (sel_rd - SEL_W'(1)) : '0;
  end

  logic         t_iss_v, t_rd_v, t_wr_v;
  logic [W-1:0] t_iss_d, t_rd_d, t_wr_d;

  pcas_tap #(.DEPTH(DEPTH), .W(W), .SEL_W(SEL_W)) u_tap_iss (
    .sel(sel_iss), .now_v(rw_fire), .now_d(now_d), .hv(hv), .hd(hd),
    .v(t_iss_v), .d(t_iss_d)
  );

  pcas_tap #(.DEPTH(DEPTH), .W(W), .SEL_W(SEL_W)) u_tap_rd (
    .sel(sel_rd), .now_v(rw_fire), .now_d(now_d), .hv(hv), .hd(hd),
    .v(t_rd_v), .d(t_rd_d)
  );

  pcas_tap #(.DEPTH(DEPTH), .W(W), .SEL_W(SEL_W)) u_tap_wr (
    .sel(sel_wr), .now_v(rw_fire), .now_d(now_d), .hv(hv), .hd(hd),
    .v(t_wr_v), .d(t_wr_d)
  );

  always_comb begin
    iss_valid = t_iss_v;
    iss_write = t_iss_d[W-1];
    iss_ba    = t_iss_d[COL_W +: BA_W];
    iss_col   = t_iss_d[COL_W-1:0];
    rd_due    = cl_set && t_rd_v && !t_rd_d[W-1];
    wr_due    = cl_set && t_wr_v && t_wr_d[W-1];
  end

  // R6
  al_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rw_fire && al_value == '0) |-> (iss_valid && iss_col == cmd_addr[COL_W-1:0] && iss_ba == cmd_ba));

  // R6
  al_one_chk: assert property (@(posedge clk) disable iff (rst)
    (rw_fire && al_value == LAT_W'(1)) |=> iss_valid);

  // R10
  cl_unset_chk: assert property (@(posedge clk) disable iff (rst)
    (cl_value == '0) |-> (!rd_due && !wr_due));

  // R12
  ready_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready);

endmodule

// File: tb/sim_pcas_latency_ctrl.sv
`timescale 1ns/1ps
module sim_pcas_latency_ctrl;

  typedef struct {
    int       cyc;
    bit       wr;
    bit [2:0] ba;
    bit [9:0] col;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b11;
  logic [2:0]  cmd_ba = '0;
  logic [15:0] cmd_addr = '0;
  logic        iss_valid, iss_write, rd_due, wr_due;
  logic [2:0]  iss_ba;
  logic [9:0]  iss_col;
  logic [2:0]  cl_value, al_value;
  logic        srt_2x, mrs_illegal, mrs_reserved;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_al = 0;
  int m_cl = 0;
  exp_t iq[$];
  exp_t rq[$];
  exp_t wq[$];
  exp_t e_i, e_r, e_w;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pcas_latency_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_ba(iss_ba), .iss_col(iss_col),
    .rd_due(rd_due), .wr_due(wr_due), .cl_value(cl_value), .al_value(al_value),
    .srt_2x(srt_2x), .mrs_illegal(mrs_illegal), .mrs_reserved(mrs_reserved)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as outputs appear
  always @(negedge clk) begin
    #5;
    if (iss_valid) begin
      if (iq.size() == 0) chk("R6", "unexpected issue at cycle", cyc, -1);
      else begin
        e_i = iq.pop_front();
        chk("R6", "issue cycle", cyc, e_i.cyc);
        chk("R9", "issue kind", int'(iss_write), int'(e_i.wr));
        chk("R9", "issue bank", int'(iss_ba), int'(e_i.ba));
        chk("R9", "issue column", int'(iss_col), int'(e_i.col));
      end
    end else if (iq.size() > 0 && iq[0].cyc <= cyc) begin
      e_i = iq.pop_front();
      chk("R6", "missed issue due at", cyc, e_i.cyc - 1000);
    end
    if (rd_due) begin
      if (rq.size() == 0) chk("R7", "unexpected rd_due at cycle", cyc, -1);
      else begin
        e_r = rq.pop_front();
        chk("R7", "rd_due cycle", cyc, e_r.cyc);
      end
    end else if (rq.size() > 0 && rq[0].cyc <= cyc) begin
      e_r = rq.pop_front();
      chk("R7", "missed rd_due due at", cyc, e_r.cyc - 1000);
    end
    if (wr_due) begin
      if (wq.size() == 0) chk("R8", "unexpected wr_due at cycle", cyc, -1);
      else begin
        e_w = wq.pop_front();
        chk("R8", "wr_due cycle", cyc, e_w.cyc);
      end
    end else if (wq.size() > 0 && wq[0].cyc <= cyc) begin
      e_w = wq.pop_front();
      chk("R8", "missed wr_due due at", cyc, e_w.cyc - 1000);
    end
  end

  task automatic rw(bit wr, bit [2:0] ba, bit [9:0] col);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = wr ? 2'b10 : 2'b01;
    cmd_ba    = ba;
    cmd_addr  = {6'b0, col};
    e.wr = wr; e.ba = ba; e.col = col;
    e.cyc = cyc + m_al;
    iq.push_back(e);
    if (m_cl != 0) begin
      e.cyc = cyc + m_al + m_cl - (wr ? 1 : 0);
      if (wr) wq.push_back(e);
      else    rq.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 2'b11;
    end
  endtask

  task automatic mrs(bit [2:0] ba, bit [15:0] a, bit e_ill, bit e_rsv, string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'b00;
    cmd_ba    = ba;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b11;
    #5;
    chk(tag, "mrs_illegal", int'(mrs_illegal), int'(e_ill));
    chk(tag, "mrs_reserved", int'(mrs_reserved), int'(e_rsv));
  endtask

  task automatic settings(string tag, int cl, int al, int srt);
    chk(tag, "cl_value", int'(cl_value), cl);
    chk(tag, "al_value", int'(al_value), al);
    chk(tag, "srt_2x", int'(srt_2x), srt);
  endtask

  task automatic drained(string tag);
    idle(16);
    chk(tag, "pending expectations", iq.size() + rq.size() + wq.size(), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R12", "cmd_ready in reset", int'(cmd_ready), 0);
    rst = 1'b0;
    #1;
    // R11 reset state
    settings("R11", 0, 0, 0);
    chk("R11", "flags after reset", int'(mrs_illegal) + int'(mrs_reserved), 0);
    chk("R12", "cmd_ready after reset", int'(cmd_ready), 1);

    // R1 / R2: MR write picks CAS latency
    mrs(3'b000, 16'h0050, 0, 0, "R2"); m_cl = 5;
    settings("R2", 5, 0, 0);
    mrs(3'b000, 16'h0020, 1, 0, "R2");
    settings("R2", 5, 0, 0);
    mrs(3'b000, 16'h0070, 1, 0, "R2");
    settings("R2", 5, 0, 0);
    // R3: EMR write picks additive latency
    mrs(3'b001, 16'h0018, 0, 0, "R3"); m_al = 3;
    settings("R3", 5, 3, 0);
    mrs(3'b001, 16'h0038, 1, 0, "R3");
    settings("R3", 5, 3, 0);
    // R4: EMR2 self-refresh temperature bit
    mrs(3'b010, 16'h0080, 0, 0, "R4");
    settings("R4", 5, 3, 1);
    // R1: EMR3 has no effect
    mrs(3'b011, 16'h00FF, 0, 0, "R1");
    settings("R1", 5, 3, 1);
    // R5: reserved bits drop the write
    mrs(3'b101, 16'h0008, 0, 1, "R5");
    settings("R5", 5, 3, 1);
    mrs(3'b001, 16'h2008, 0, 1, "R5");
    settings("R5", 5, 3, 1);
    mrs(3'b000, 16'h8030, 0, 1, "R5");
    settings("R5", 5, 3, 1);

    // R12: op 11 ignored (monitor flags any output)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_ba = 3'b001; cmd_addr = 16'h0008;
    idle(1);
    #5;
    settings("R12", 5, 3, 1);
    drained("R12");

    // R6 R7 R8 with AL=3 CL=5
    rw(0, 3'd2, 10'h055);
    idle(1);
    drained("R7");
    rw(1, 3'd6, 10'h2AA);
    idle(1);
    drained("R8");
    // R9 back-to-back mix
    rw(0, 3'd1, 10'h001);
    rw(1, 3'd2, 10'h102);
    rw(1, 3'd3, 10'h203);
    rw(0, 3'd4, 10'h304);
    idle(1);
    drained("R9");

    // AL=0 CL=3: same-cycle issue
    mrs(3'b001, 16'h0000, 0, 0, "R3"); m_al = 0;
    mrs(3'b000, 16'h0030, 0, 0, "R2"); m_cl = 3;
    settings("R6", 3, 0, 1);
    rw(0, 3'd7, 10'h3FF);
    rw(1, 3'd0, 10'h000);
    idle(1);
    drained("R6");

    // AL=6 CL=6: deepest pipeline, back-to-back
    mrs(3'b001, 16'h0030, 0, 0, "R3"); m_al = 6;
    mrs(3'b000, 16'h0060, 0, 0, "R2"); m_cl = 6;
    for (int k = 0; k < 5; k++) rw(k[0], 3'(k), 10'(k * 37 + 5));
    idle(1);
    drained("R9");

    // R11: reset with commands in flight
    rw(0, 3'd5, 10'h111);
    rw(0, 3'd6, 10'h222);
    rw(1, 3'd7, 10'h333);
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    iq.delete(); rq.delete(); wq.delete();
    m_al = 0; m_cl = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    settings("R11", 0, 0, 0);
    drained("R11");

    // R10: CL unprogrammed, issue only
    rw(0, 3'd3, 10'h0F0);
    rw(1, 3'd4, 10'h0F1);
    idle(1);
    drained("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule